// File: doc/BRIEF.md
# Pause Frame Classifier

This block inspects each received Ethernet frame as it streams past, one byte per valid cycle, and decides what the receive path should do with it once the final byte has arrived. It tracks the byte count, picks up the type field, the opcode and the 16-bit pause time from fixed byte positions, and combines them with two verdicts made elsewhere: a CRC-good flag and a destination-address-hit flag. Both verdicts are presented together with the last byte.

One cycle after the last byte, the block reports a disposition (normal, control or reject) and a forward-to-host flag. When the frame is a well-formed pause request, it also issues a one-cycle pause strobe that carries the requested pause time. A configuration input selects between two policies for control frames. Either they are consumed silently, or they are also handed to the host, so that drivers that do not know about flow control can still run with flow control switched on.

The rules are applied in a fixed order. A frame shorter than the header is rejected. Any other frame with a non-control type is passed on as normal data. A control-type frame whose address misses is rejected. Every remaining control-type frame is tagged as control, and it triggers a pause only when its length, CRC and opcode are all correct.

Top module: `pause_frame_classifier`

## Requirements
- R1: After reset, `res_valid`, `pause_go` and `res_fwd` are 0 and `res_disp` is 2'b00.
- R2: `res_valid` is high for exactly the one cycle that follows each cycle in which `in_valid` and `in_eof` are both high, and it is low otherwise. `crc_ok`, `da_hit` and `pass_thru` are sampled in that end-of-frame cycle.
- R3: A frame of 18 bytes or more whose bytes 12 and 13 (byte 0 is the `in_sof` byte, high byte first) are not 16'h8808 is reported as normal, with `res_fwd`=1 and no pause. This holds whatever the values of `crc_ok` and `da_hit`.
- R4: A frame of 18 bytes or more with type 16'h8808 and `da_hit`=0 is reported as reject, with `res_fwd`=0 and no pause.
- R5: A frame shorter than 18 bytes is reported as reject, with `res_fwd`=0 and no pause. This includes a frame whose `in_sof` and `in_eof` fall in the same byte.
- R6: A frame of exactly 64 bytes (CRC included) with type 16'h8808, `da_hit`=1, `crc_ok`=1 and opcode 16'h0001 in bytes 14 and 15 raises `pause_go` for one cycle, together with `res_valid`. In that cycle `pause_time` equals bytes 16 and 17 taken big-endian.
- R7: A control-type frame with an address hit whose length is not 64 bytes is reported as control and raises no pause.
- R8: A 64-byte control-type frame with an address hit but with `crc_ok`=0 or an opcode other than 16'h0001 is reported as control and raises no pause.
- R9: For a control disposition, `res_fwd` equals `pass_thru`.
- R10: `res_disp` uses 2'b00 for normal, 2'b01 for control and 2'b10 for reject, and never shows 2'b11 while `res_valid` is high. `pause_go` is high only together with the control disposition.
- R11: An `in_sof` byte that arrives in the cycle right after an end-of-frame starts a new frame. The earlier frame's result does not disturb the new frame, and the new frame does not disturb that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_thru | input | 1 | 1: control frames are also forwarded to the host |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sof | input | 1 | The current byte is the first byte of a frame |
| in_eof | input | 1 | The current byte is the last byte of a frame (CRC included) |
| in_data | input | 8 | Frame byte |
| crc_ok | input | 1 | CRC verdict, valid with the end-of-frame byte |
| da_hit | input | 1 | Destination address accepted, valid with the end-of-frame byte |
| res_valid | output | 1 | Classification result strobe |
| res_disp | output | 2 | Disposition: 00 normal, 01 control, 10 reject |
| res_fwd | output | 1 | Forward the frame to the host |
| pause_go | output | 1 | One-cycle pause command |
| pause_time | output | 16 | Pause time that goes with `pause_go` |

## Verification
Two things can fall in the same cycle here: the result of one frame and the first byte of the next, or, for a one-byte frame, the start and the end of a single frame. The bench drives 64-byte pause frames back to back with no idle cycle between them, then a run of one-byte frames whose start and end markers coincide. Each result is popped from the scoreboard in order and compared. A pause time or disposition that leaked from one frame into the next would show up as a mismatch against that frame's own expected entry.

// File: rtl/pause_frame_classifier.sv
module pause_frame_classifier #(
  parameter int          CNT_W    = 12,
  parameter int          CTL_LEN  = 64,
  parameter int          HDR_LEN  = 18,
  parameter logic [15:0] CTL_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pass_thru,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic        crc_ok,
  input  logic        da_hit,
  output logic        res_valid,
  output logic [1:0]  res_disp,
  output logic        res_fwd,
  output logic        pause_go,
  output logic [15:0] pause_time
);
  localparam logic [1:0] D_NORM = 2'b00;
  localparam logic [1:0] D_CTRL = 2'b01;
  localparam logic [1:0] D_REJ  = 2'b10;
  localparam logic [CNT_W-1:0] OFS_TYPE = CNT_W'(12);

  logic [CNT_W-1:0] cnt_q, idx, len_n;
  logic [15:0]      typ_q, op_q, tim_q;
  logic [15:0]      typ_n, op_n, tim_n;
  logic [1:0]       disp_n;
  logic             fire, short_n, go_n, fwd_n;

  assign idx   = in_sof ? '0 : cnt_q;
  assign len_n = (&idx) ? idx : idx + 1'b1;
  assign fire  = in_valid & in_eof;

  always_comb begin
    typ_n = typ_q;
    op_n  = op_q;
    tim_n = tim_q;
    if (in_valid) begin
      case (idx)
        OFS_TYPE:           typ_n[15:8] = in_data;
        OFS_TYPE + 1'b1:    typ_n[7:0]  = in_data;
        OFS_TYPE + 2'd2:    op_n[15:8]  = in_data;
        OFS_TYPE + 2'd3:    op_n[7:0]   = in_data;
        OFS_TYPE + 3'd4:    tim_n[15:8] = in_data;
        OFS_TYPE + 3'd5:    tim_n[7:0]  = in_data;
        default: ;
      endcase
    end
  end

  assign short_n = len_n < CNT_W'(HDR_LEN);
  assign disp_n  = short_n             ? D_REJ  :
                   (typ_n != CTL_TYPE) ? D_NORM :
                   !da_hit             ? D_REJ  : D_CTRL;
  assign fwd_n   = (disp_n == D_NORM) | ((disp_n == D_CTRL) & pass_thru);
  assign go_n    = (disp_n == D_CTRL) && (len_n == CNT_W'(CTL_LEN))
                   && crc_ok && (op_n == PAUSE_OP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      typ_q      <= '0;
      op_q       <= '0;
      tim_q      <= '0;
      res_valid  <= 1'b0;
      res_disp   <= D_NORM;
      res_fwd    <= 1'b0;
      pause_go   <= 1'b0;
      pause_time <= '0;
    end else begin
      if (in_valid) cnt_q <= fire ? '0 : len_n;
      typ_q      <= typ_n;
      op_q       <= op_n;
      tim_q      <= tim_n;
      res_valid  <= fire;
      res_disp   <= fire ? disp_n : D_NORM;
      res_fwd    <= fire & fwd_n;
      pause_go   <= fire & go_n;
      if (fire & go_n) pause_time <= tim_n;
    end
  end
endmodule

module pause_frame_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pass_thru,
  input logic       in_valid,
  input logic       in_eof,
  input logic       crc_ok,
  input logic       da_hit,
  input logic       res_valid,
  input logic [1:0] res_disp,
  input logic       res_fwd,
  input logic       pause_go
);
  // R2
  result_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eof) |=> res_valid);
  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_eof));
  // R10
  disp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_disp != 2'b11));
  // R10
  pause_only_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_go |-> (res_valid && res_disp == 2'b01));
  // R6
  pause_needs_crc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_go |-> $past(crc_ok && da_hit));
  // R4
  reject_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_disp == 2'b10) |-> !res_fwd);
  // R3
  normal_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_disp == 2'b00) |-> res_fwd);
  // R9
  ctrl_fwd_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_disp == 2'b01) |-> (res_fwd == $past(pass_thru)));
endmodule

bind pause_frame_classifier pause_frame_classifier_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pass_thru(pass_thru), .in_valid(in_valid),
  .in_eof(in_eof), .crc_ok(crc_ok), .da_hit(da_hit), .res_valid(res_valid),
  .res_disp(res_disp), .res_fwd(res_fwd), .pause_go(pause_go)
);

// File: tb/pause_frame_classifier_tb.sv
module pause_frame_classifier_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, pass_thru = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = '0;
  logic crc_ok = 1'b0, da_hit = 1'b0;
  logic res_valid, res_fwd, pause_go;
  logic [1:0] res_disp;
  logic [15:0] pause_time;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  typedef struct packed { logic [1:0] d; logic f; logic p; logic [15:0] q; } exp_t;
  exp_t  sb[$];
  string tg[$];

  always #2 clk = ~clk;

  pause_frame_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .pass_thru(pass_thru), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .crc_ok(crc_ok),
    .da_hit(da_hit), .res_valid(res_valid), .res_disp(res_disp),
    .res_fwd(res_fwd), .pause_go(pause_go), .pause_time(pause_time)
  );

  task automatic send(input int len, input logic [15:0] typ, input logic [15:0] op,
                      input logic [15:0] qt, input bit crc, input bit hit,
                      input int gap, input string tag);
    exp_t e;
    if (len < 18)              begin e.d = 2'b10; e.f = 1'b0; e.p = 1'b0; end
    else if (typ != 16'h8808)  begin e.d = 2'b00; e.f = 1'b1; e.p = 1'b0; end
    else if (!hit)             begin e.d = 2'b10; e.f = 1'b0; e.p = 1'b0; end
    else begin
      e.d = 2'b01; e.f = pass_thru;
      e.p = (len == 64) && crc && (op == 16'h0001);
    end
    e.q = qt;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      crc_ok   = (i == len - 1) ? crc : 1'b0;
      da_hit   = (i == len - 1) ? hit : 1'b0;
      case (i)
        12: in_data = typ[15:8];
        13: in_data = typ[7:0];
        14: in_data = op[15:8];
        15: in_data = op[7:0];
        16: in_data = qt[15:8];
        17: in_data = qt[7:0];
        default: in_data = 8'(i) ^ 8'h5A;
      endcase
      if (i == len - 1) begin sb.push_back(e); tg.push_back(tag); end
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; crc_ok = 1'b0; da_hit = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        n_run++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL R2: result with no frame pending, disp=%b expected none", res_disp);
        end else begin
          exp_t e; string t;
          e = sb.pop_front(); t = tg.pop_front();
          if (res_disp !== e.d || res_fwd !== e.f || pause_go !== e.p ||
              (e.p && pause_time !== e.q)) begin
            n_fail++;
            $display("FAIL %s: disp=%b fwd=%b go=%b time=%h expected disp=%b fwd=%b go=%b time=%h",
                     t, res_disp, res_fwd, pause_go, pause_time, e.d, e.f, e.p, e.q);
          end
        end
      end else if (pause_go) begin
        n_run++; n_fail++;
        $display("FAIL R10: pause_go=1 without result, expected 0");
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_run++;
    if (res_valid !== 1'b0 || pause_go !== 1'b0 || res_fwd !== 1'b0 || res_disp !== 2'b00) begin
      n_fail++;
      $display("FAIL R1: valid=%b go=%b fwd=%b disp=%b expected 0 0 0 00",
               res_valid, pause_go, res_fwd, res_disp);
    end
    rst_n = 1'b1;
    pass_thru = 1'b1;
    send(64, 16'h8808, 16'h0001, 16'h1234, 1, 1, 2, "R6");
    pass_thru = 1'b0;
    send(64, 16'h8808, 16'h0001, 16'hFFFF, 1, 1, 2, "R9");
    pass_thru = 1'b1;
    send(64, 16'h8808, 16'h0003, 16'h0101, 1, 1, 2, "R9");
    send(64, 16'h0800, 16'h0001, 16'h1111, 1, 0, 2, "R3");
    send(70, 16'h86DD, 16'h0001, 16'h2222, 0, 1, 1, "R3");
    send(64, 16'h8808, 16'h0001, 16'h3333, 1, 0, 2, "R4");
    send(10, 16'h8808, 16'h0001, 16'h4444, 1, 1, 2, "R5");
    send(17, 16'h8808, 16'h0001, 16'h4444, 1, 1, 2, "R5");
    send(65, 16'h8808, 16'h0001, 16'h5555, 1, 1, 2, "R7");
    send(60, 16'h8808, 16'h0001, 16'h6666, 1, 1, 2, "R7");
    send(18, 16'h8808, 16'h0001, 16'h6767, 1, 1, 2, "R7");
    send(64, 16'h8808, 16'h0001, 16'h7777, 0, 1, 2, "R8");
    send(64, 16'h8808, 16'h0002, 16'h8888, 1, 1, 2, "R8");
    send(64, 16'h8808, 16'h0001, 16'hA5C3, 1, 1, 0, "R11");
    send(64, 16'h8808, 16'h0001, 16'h00AB, 1, 1, 0, "R11");
    send(64, 16'h0800, 16'h0001, 16'h0000, 1, 1, 0, "R11");
    send(1,  16'h8808, 16'h0001, 16'h0000, 1, 1, 0, "R5");
    send(1,  16'h8808, 16'h0001, 16'h0000, 1, 1, 0, "R11");
    send(64, 16'h8808, 16'h0001, 16'hBEEF, 1, 1, 4, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule